// File: doc/BRIEF.md
# Serial Transmitter with Read-Back Collision Check

This block sends bytes on a single-wire, open-drain style serial bus and watches the bus level it reads back while each frame goes out. A frame is a start bit, eight data bits sent least significant bit first, and a stop bit. Each bit lasts sixteen ticks of an oversampling strobe. Software places a byte in a one-entry holding register with a write strobe. The transmitter moves that byte into its shift register as soon as the line is free.

While a frame is in flight, the level received from the bus passes through a two-flop synchronizer and is compared, once per bit, with the level being driven. A 2-bit check mode selects whether the compare is made and at which tick of the bit. When the two levels differ, the frame is cut short and the line returns to idle. Any byte waiting in the holding register is dropped, and a sticky error flag is raised. No further frame starts, and no new byte is accepted, until software pulses the clear input. Separate polarity bits invert the transmit and receive pins. They must be set alike for the compare to be meaningful.

The controller is a four-state machine. IDLE goes to START on "load", when a byte is held and the error flag is low. START goes to DATA at "bit end". DATA stays in DATA for each data bit and goes to STOP at "bit end" after the eighth bit. STOP goes to IDLE on "frame end". START, DATA and STOP each go to IDLE on "abort", which is a read-back mismatch at the compare point.

Top module: `ctx_tx_top`

## Requirements
- R1: The logical line level is 1 when idle, 0 for the start bit, then data bits 0 through 7, then 1 for the stop bit. Each bit lasts 16 `tick16` strobes. `tx_pin` equals the logical level XOR `tx_inv`.
- R2: After reset, `tx_pin` shows idle, `empty_flag` = 1, `done_flag` = 1 and `err_flag` = 0. A write is accepted only when `empty_flag` = 1 and `err_flag` = 0. `empty_flag` rises when the byte moves to the shifter. `done_flag` is 0 from frame start until the stop bit ends.
- R3: `chk_mode` 2'b01 compares at bit-tick count 8 (the 9th strobe of the bit). 2'b10 compares at count 12 (the 13th strobe). 2'b00 and 2'b11 make no compare. The compared level is `rx_pin` XOR `rx_inv` after a 2-flop synchronizer.
- R4: No compare is made while the transmitter is idle. A mismatching bus level seen in IDLE leaves `err_flag` at 0.
- R5: On a mismatch, the frame ends at once and the holding register is emptied. Both `empty_flag` and `done_flag` read 1 afterwards.
- R6: A mismatch sets `err_flag`. While `err_flag` = 1, no frame starts and writes are ignored.
- R7: A pulse on `err_clr` clears `err_flag`. A disabled check mode (2'b00 or 2'b11) forces `err_flag` to 0.
- R8: After an abort, `tx_pin` sits at the idle level: high when `tx_inv` = 0 and low when `tx_inv` = 1.
- R9: A bus disturbance that ends before the selected compare point of a bit does not cause an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle oversampling strobe, 16 per bit |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| rx_pin | input | 1 | Level read back from the bus |
| chk_mode | input | 2 | Compare mode: 01 early point, 10 late point, 00/11 off |
| tx_inv | input | 1 | Invert transmit pin |
| rx_inv | input | 1 | Invert receive pin |
| err_clr | input | 1 | Clear strobe for the error flag |
| tx_pin | output | 1 | Transmit pin |
| empty_flag | output | 1 | Holding register empty |
| done_flag | output | 1 | No frame in flight |
| err_flag | output | 1 | Sticky bit-error flag |

## Verification
The bench inverts the read-back level for a window of chosen strobes within the fourth bit of a frame. Opening the window just before count 8 and closing it before count 12 separates the two compare points. A design that sampled at the wrong tick would abort in the late mode or miss the error in the early mode. After an abort the bench checks that a second queued byte never appears on the line, that writes are refused while the flag is set, and that the line rests at the idle level for both polarities; a design that forgot to flush or to block would emit an extra frame. It also drives a mismatching level while idle and with the check disabled, to catch a compare that runs outside a frame. It switches a set flag to a disabled mode, to catch an error flag that does not clear.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_START = 2'd1,
        S_DATA  = 2'd2,
        S_STOP  = 2'd3
    } tx_state_e;

    localparam logic [1:0] CHK_EARLY = 2'b01;
    localparam logic [1:0] CHK_LATE  = 2'b10;

    function automatic logic chk_enabled(input logic [1:0] mode);
        return (mode == CHK_EARLY) || (mode == CHK_LATE);
    endfunction
endpackage

// File: rtl/ctx_sync.sv
module ctx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ctx_holdreg.sv
module ctx_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              blocked,
    input  logic              pop,
    input  logic              flush,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (flush) begin
            full <= 1'b0;
        end else if (pop) begin
            full <= 1'b0;
        end else if (wr && !full && !blocked) begin
            full <= 1'b1;
            data <= wdata;
        end
    end

    // R5: an abort leaves nothing held
    p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !full);

    // R2: a held byte stays put until it is taken or dropped
    p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !flush) |=> (full && $stable(data)));
endmodule

// File: rtl/ctx_errflag.sv
module ctx_errflag (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] chk_mode,
    input  logic       set,
    input  logic       clr,
    output logic       err
);
    import ctx_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (!chk_enabled(chk_mode)) begin
            err <= 1'b0;
        end else if (set) begin
            err <= 1'b1;
        end else if (clr) begin
            err <= 1'b0;
        end
    end

    // R7: a disabled mode forces the flag low
    p_off_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_enabled(chk_mode) |=> !err);

    // R6: a mismatch raises the flag
    p_set_on_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set && chk_enabled(chk_mode)) |=> err);
endmodule

// File: rtl/ctx_fsm.sv
module ctx_fsm #(
    parameter int DATA_W   = 8,
    parameter int OVS      = 16,
    parameter int EARLY_PT = 8,
    parameter int LATE_PT  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              blocked,
    input  logic [1:0]        chk_mode,
    input  logic              rx_bit,
    output logic              load,
    output logic              abort,
    output logic              line_lvl,
    output logic              done_flag
);
    import ctx_pkg::*;

    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] EARLY_CNT = CNT_W'(EARLY_PT);
    localparam logic [CNT_W-1:0] LATE_CNT  = CNT_W'(LATE_PT);
    localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(DATA_W - 1);

    tx_state_e         state, nxt;
    logic [CNT_W-1:0]  tick_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              bit_end, cmp_hit;
    logic [CNT_W-1:0]  cmp_pt;

    assign bit_end = tick && (tick_cnt == LAST_TICK);
    assign cmp_pt  = (chk_mode == CHK_LATE) ? LATE_CNT : EARLY_CNT;
    assign cmp_hit = tick && (tick_cnt == cmp_pt);
    assign load    = (state == S_IDLE) && buf_full && !blocked;
    assign abort   = chk_enabled(chk_mode) && (state != S_IDLE)
                     && cmp_hit && (rx_bit != line_lvl);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (load) nxt = S_START;
            S_START: if (abort) nxt = S_IDLE;
                     else if (bit_end) nxt = S_DATA;
            S_DATA:  if (abort) nxt = S_IDLE;
                     else if (bit_end && bit_idx == LAST_BIT) nxt = S_STOP;
            S_STOP:  if (abort || bit_end) nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            S_IDLE:  line_lvl = 1'b1;
            S_START: line_lvl = 1'b0;
            S_DATA:  line_lvl = shreg[0];
            S_STOP:  line_lvl = 1'b1;
        endcase
    end

    // bit timing and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
        end else if (state == S_IDLE || abort) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
            if (load) shreg <= buf_data;
        end else if (tick) begin
            tick_cnt <= tick_cnt + 1'b1;
            if (bit_end && state == S_DATA) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b1;
        end else if (load) begin
            done_flag <= 1'b0;
        end else if (abort || (state == S_STOP && bit_end)) begin
            done_flag <= 1'b1;
        end
    end

    // R5: a mismatch ends the frame and reports it complete
    p_abort_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == S_IDLE && done_flag));

    // R6: a raised error keeps the machine parked
    p_blocked_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && blocked) |=> (state == S_IDLE));

    // R2: a started frame is not complete
    p_busy_not_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done_flag);
endmodule

// File: rtl/ctx_tx_top.sv
module ctx_tx_top #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int EARLY_PT    = 8,
    parameter int LATE_PT     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rx_pin,
    input  logic [1:0]        chk_mode,
    input  logic              tx_inv,
    input  logic              rx_inv,
    input  logic              err_clr,
    output logic              tx_pin,
    output logic              empty_flag,
    output logic              done_flag,
    output logic              err_flag
);
    logic              rx_bit, buf_full, load, abort, line_lvl;
    logic [DATA_W-1:0] buf_data;

    ctx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rx_pin ^ rx_inv), .q(rx_bit)
    );

    ctx_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr(wr_stb), .wdata(wr_data),
        .blocked(err_flag), .pop(load), .flush(abort),
        .full(buf_full), .data(buf_data)
    );

    ctx_errflag u_err (
        .clk(clk), .rst_n(rst_n), .chk_mode(chk_mode),
        .set(abort), .clr(err_clr), .err(err_flag)
    );

    ctx_fsm #(
        .DATA_W(DATA_W), .OVS(OVS), .EARLY_PT(EARLY_PT), .LATE_PT(LATE_PT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .buf_full(buf_full),
        .buf_data(buf_data), .blocked(err_flag), .chk_mode(chk_mode),
        .rx_bit(rx_bit), .load(load), .abort(abort), .line_lvl(line_lvl),
        .done_flag(done_flag)
    );

    assign tx_pin     = line_lvl ^ tx_inv;
    assign empty_flag = !buf_full;

    // R8: the pin rests at the idle level right after an abort
    p_idle_after_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> ((tx_pin ^ tx_inv) == 1'b1));

    // R5: an abort leaves the holding register reported empty
    p_empty_after_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> empty_flag);
endmodule

// File: tb/ctx_tx_top_tb.sv
module ctx_tx_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [1:0] div = 2'd0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rx_pin;
    logic [1:0] chk_mode = 2'b01;
    logic       tx_inv = 1'b0;
    logic       rx_inv = 1'b0;
    logic       err_clr = 1'b0;
    logic       tx_pin, empty_flag, done_flag, err_flag;
    logic       glitch = 1'b0;
    logic       mon_en = 1'b1;
    int         checks = 0;
    int         errors = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        div    <= div + 2'd1;
        tick16 <= (div == 2'd2);
    end

    assign rx_pin = glitch ? ~tx_pin : tx_pin;

    ctx_tx_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_stb(wr_stb),
        .wr_data(wr_data), .rx_pin(rx_pin), .chk_mode(chk_mode),
        .tx_inv(tx_inv), .rx_inv(rx_inv), .err_clr(err_clr),
        .tx_pin(tx_pin), .empty_flag(empty_flag), .done_flag(done_flag),
        .err_flag(err_flag)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            if (tick16) k++;
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    // driver: pushes the expected byte into the scoreboard
    task automatic send(input logic [7:0] b, input bit expect_out);
        do @(negedge clk); while (!empty_flag);
        if (expect_out) exp_q.push_back(b);
        write_byte(b);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!(done_flag && empty_flag && exp_q.size() == 0));
    endtask

    // invert the read-back level between two strobe counts of a frame
    task automatic glitch_frame(input int from_t, input int to_t);
        int k;
        do @(negedge clk); while ((tx_pin ^ tx_inv) != 1'b0);
        k = tick16 ? 1 : 0;
        while (k < from_t) begin @(negedge clk); if (tick16) k++; end
        glitch = 1'b1;
        while (k < to_t) begin @(negedge clk); if (tick16) k++; end
        glitch = 1'b0;
    endtask

    task automatic idle_watch(input int n, input logic lvl, input string req);
        int bad = 0;
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            if (tick16) k++;
            if (tx_pin !== lvl) bad++;
        end
        chk(bad == 0, req, "line left idle level (cycles)", bad, 0);
    endtask

    // monitor: decodes the line and pops the scoreboard
    initial begin
        int k;
        logic [7:0] got;
        logic [7:0] want;
        forever begin
            @(negedge clk);
            if (mon_en && rst_n && (tx_pin ^ tx_inv) == 1'b0) begin
                k = tick16 ? 1 : 0;
                while (k < 8) begin @(negedge clk); if (tick16) k++; end
                chk((tx_pin ^ tx_inv) == 1'b0, "R1", "start bit", tx_pin ^ tx_inv, 0);
                for (int i = 0; i < 8; i++) begin
                    while (k < 24 + 16 * i) begin @(negedge clk); if (tick16) k++; end
                    got[i] = tx_pin ^ tx_inv;
                end
                while (k < 152) begin @(negedge clk); if (tick16) k++; end
                chk((tx_pin ^ tx_inv) == 1'b1, "R1", "stop bit", tx_pin ^ tx_inv, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1", "unexpected frame", got, 0);
                end else begin
                    want = exp_q.pop_front();
                    chk(got == want, "R1", "frame data", got, want);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(tx_pin == 1'b1, "R2", "reset tx_pin", tx_pin, 1);
        chk(empty_flag == 1'b1, "R2", "reset empty", empty_flag, 1);
        chk(done_flag == 1'b1, "R2", "reset done", done_flag, 1);
        chk(err_flag == 1'b0, "R2", "reset err", err_flag, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R2: plain frames, mode 01, loopback clean
        send(8'hA5, 1'b1);
        do @(negedge clk); while (!empty_flag);
        chk(done_flag == 1'b0, "R2", "done low during frame", done_flag, 0);
        send(8'h3C, 1'b1);
        wait_done();
        chk(done_flag == 1'b1, "R2", "done after frame", done_flag, 1);
        chk(err_flag == 1'b0, "R1", "no error on clean loopback", err_flag, 0);

        // R9 R3: late compare point misses a disturbance before count 12
        chk_mode = 2'b10;
        send(8'h5A, 1'b1);
        glitch_frame(54, 59);
        wait_done();
        chk(err_flag == 1'b0, "R9", "late mode ignores early disturbance", err_flag, 0);

        // R3: disabled encodings make no compare
        chk_mode = 2'b00;
        send(8'h0F, 1'b1);
        glitch_frame(20, 140);
        wait_done();
        chk(err_flag == 1'b0, "R3", "mode 00 no compare", err_flag, 0);
        chk_mode = 2'b11;
        send(8'hF0, 1'b1);
        glitch_frame(20, 140);
        wait_done();
        chk(err_flag == 1'b0, "R3", "mode 11 no compare", err_flag, 0);

        // R4: mismatching bus while idle
        chk_mode = 2'b01;
        @(negedge clk);
        glitch = 1'b1;
        idle_watch(60, 1'b1, "R4");
        glitch = 1'b0;
        chk(err_flag == 1'b0, "R4", "no compare while idle", err_flag, 0);

        // R3 R5 R6: early point catches the same disturbance, abort
        mon_en = 1'b0;
        send(8'h3C, 1'b0);
        do @(negedge clk); while (!empty_flag);
        write_byte(8'hA5);
        chk(empty_flag == 1'b0, "R2", "second byte held", empty_flag, 0);
        glitch_frame(50, 60);
        chk(err_flag == 1'b1, "R6", "error raised", err_flag, 1);
        chk(empty_flag == 1'b1, "R5", "held byte dropped", empty_flag, 1);
        chk(done_flag == 1'b1, "R5", "done after abort", done_flag, 1);
        chk(tx_pin == 1'b1, "R8", "idle high after abort", tx_pin, 1);
        idle_watch(200, 1'b1, "R6");
        write_byte(8'h77);
        @(negedge clk);
        chk(empty_flag == 1'b1, "R6", "write ignored while error", empty_flag, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(err_flag == 1'b0, "R7", "clear strobe", err_flag, 0);
        idle_watch(200, 1'b1, "R5");
        chk(empty_flag == 1'b1, "R5", "nothing left after clear", empty_flag, 1);
        mon_en = 1'b1;
        send(8'h81, 1'b1);
        wait_done();

        // R8 R7: inverted polarity, abort, then disabled mode clears
        @(negedge clk);
        tx_inv = 1'b1;
        rx_inv = 1'b1;
        @(negedge clk);
        chk(tx_pin == 1'b0, "R8", "inverted idle low", tx_pin, 0);
        mon_en = 1'b0;
        send(8'h96, 1'b0);
        glitch_frame(50, 60);
        chk(err_flag == 1'b1, "R6", "inverted abort", err_flag, 1);
        chk(tx_pin == 1'b0, "R8", "idle low after abort", tx_pin, 0);
        chk_mode = 2'b00;
        @(negedge clk);
        chk(err_flag == 1'b0, "R7", "disabled mode clears flag", err_flag, 0);
        chk_mode = 2'b01;
        @(negedge clk);
        chk(err_flag == 1'b0, "R7", "flag stays clear", err_flag, 0);
        mon_en = 1'b1;
        send(8'hC3, 1'b1);
        wait_done();
        chk(exp_q.size() == 0, "R1", "scoreboard drained", exp_q.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule